// File: doc/BRIEF.md
# Spectral Gradient-to-Phase Coefficient Combiner

This streaming stage sits between the two forward 2-D transforms of a modal wavefront reconstructor and the inverse transform that follows them. Each clock it may accept one spectral sample from the x-slope spectrum and one from the y-slope spectrum. Both samples belong to the same frequency bin and come with the row and column counts of that bin. The x sample is weighted by i·p/(p²+q²) and the y sample by i·q/(p²+q²). The two complex products are added, and the sum is rounded to the input width of the inverse transform.

A single factor table, filled at elaboration time from its parameters, feeds both weightings. The y-path weight at (row, col) equals the x-path weight at (col, row), so the y path reads the same table with the two indices exchanged. The pipeline accepts a new sample on every clock. A valid flag travels alongside the data, so the block can take gapped or back-to-back input.

Top module: `phase_coef_combiner`

## Requirements
- R1: The x-path weight for bin (row r, col c) has a real part of zero and an imaginary part equal to round-half-up(2^14 · p / (p² + q²)), held as 16-bit two's complement. Here p and q are the signed frequencies of r and c: an index i at or above N/2 maps to i − N, where N = 2^LOG_N.
- R2: At the bin where p = q = 0, the weight is 0, and the coefficient produced at that bin is 0.
- R3: The y-path weight for bin (r, c) is the table entry at (c, r), which is i·q/(p² + q²).
- R4: Each 24-bit input component is reduced to 18 bits before it is multiplied. The reduction adds 2^5, shifts right arithmetically by 6, and saturates to [−131072, 131071].
- R5: Each complex product is formed as real = a_re·b_re − a_im·b_im and imag = a_re·b_im + a_im·b_re. The x and y products are added separately for the real part and for the imaginary part.
- R6: out_valid is in_valid delayed by exactly 7 clocks. A new sample can be accepted on every clock, and every accepted sample yields exactly one output.
- R7: Each output component is round-half-up(sum / 2^16), saturated to the 16-bit range [−32768, 32767].
- R8: While no valid sample is moving through a stage, that stage holds its register. The coefficient outputs therefore keep their last value between valid outputs.
- R9: A synchronous active-high reset clears out_valid and both coefficient outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| row_idx | input | LOG_N | Row count of the current bin |
| col_idx | input | LOG_N | Column count of the current bin |
| gx_re | input | IN_W | x-slope spectrum, real part |
| gx_im | input | IN_W | x-slope spectrum, imaginary part |
| gy_re | input | IN_W | y-slope spectrum, real part |
| gy_im | input | IN_W | y-slope spectrum, imaginary part |
| out_valid | output | 1 | Output coefficient qualifier |
| coef_re | output | OUT_W | Phase coefficient, real part |
| coef_im | output | OUT_W | Phase coefficient, imaginary part |

## Verification
The assertions check four things on every clock. out_valid must equal in_valid from seven clocks earlier. A lookup at the zero-frequency bin must return zero weights on both paths. The multiplier and the output register must hold while no valid sample reaches them. The numeric results cannot be checked that way. Only the bench scenarios show them: full 8×8 frames compared with coefficients computed from the formula, the transposed lookup at asymmetric bins, input saturation before the multiply, and output saturation after the final rounding.

// File: rtl/phase_coef_pkg.sv
`timescale 1ns/1ps
package phase_coef_pkg;

    localparam int MUL_W = 18;   // operand width entering the multipliers
    localparam int TBL_W = 16;   // width of one table part
    localparam int FRAC  = 14;   // fractional bits of the stored weights

    // Map an FFT bin index onto its signed frequency.
    function automatic int signed_freq(input int idx, input int n);
        return (idx >= n / 2) ? idx - n : idx;
    endfunction

    // Imaginary part of i*p/(p^2+q^2), scaled by 2^frac, rounded half up.
    function automatic int x_weight(input int r, input int c, input int n, input int frac);
        int p;
        int q;
        int d;
        int num;
        int den;
        p = signed_freq(r, n);
        q = signed_freq(c, n);
        d = p * p + q * q;
        if (d == 0) return 0;
        num = p * (2 ** (frac + 1)) + d;
        den = 2 * d;
        if (num >= 0) return num / den;
        return -((-num + den - 1) / den);
    endfunction

endpackage

// File: rtl/rnd_sat.sv
`timescale 1ns/1ps
// Round half up by dropping SH low bits, then saturate to OW bits. SH >= 2.
module rnd_sat #(
    parameter int IW = 24,
    parameter int OW = 18,
    parameter int SH = 6
) (
    input  logic signed [IW-1:0] din,
    output logic signed [OW-1:0] dout
);
    localparam logic signed [IW:0] HALF = {{(IW + 1 - SH){1'b0}}, 1'b1, {(SH - 1){1'b0}}};
    localparam logic signed [IW:0] MAXV = {{(IW + 2 - OW){1'b0}}, {(OW - 1){1'b1}}};
    localparam logic signed [IW:0] MINV = {{(IW + 2 - OW){1'b1}}, {(OW - 1){1'b0}}};

    logic signed [IW:0] biased;
    logic signed [IW:0] shifted;

    always_comb begin
        biased  = $signed({din[IW-1], din}) + HALF;
        shifted = biased >>> SH;
        if (shifted > MAXV)      dout = MAXV[OW-1:0];
        else if (shifted < MINV) dout = MINV[OW-1:0];
        else                     dout = shifted[OW-1:0];
    end
endmodule

// File: rtl/phase_factor_rom.sv
`timescale 1ns/1ps
// Weight table built at elaboration; two read ports, one with swapped indices.
module phase_factor_rom
    import phase_coef_pkg::*;
#(
    parameter int LOG_N = 3
) (
    input  logic [LOG_N-1:0]        row,
    input  logic [LOG_N-1:0]        col,
    output logic signed [TBL_W-1:0] fx_im,
    output logic signed [TBL_W-1:0] fy_im
);
    localparam int N = 1 << LOG_N;

    logic signed [TBL_W-1:0] rom [N * N];

    for (genvar gr = 0; gr < N; gr++) begin : g_row
        for (genvar gc = 0; gc < N; gc++) begin : g_col
            assign rom[gr * N + gc] = TBL_W'(x_weight(gr, gc, N, FRAC));
        end
    end

    assign fx_im = rom[{row, col}];
    assign fy_im = rom[{col, row}];   // transposed view serves the y path
endmodule

// File: rtl/cplx_mul_pipe.sv
`timescale 1ns/1ps
// Four-stage complex multiplier: operand reg, products, combine, output reg.
module cplx_mul_pipe #(
    parameter int AW = 18,
    parameter int BW = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic signed [AW-1:0]    a_re,
    input  logic signed [AW-1:0]    a_im,
    input  logic signed [BW-1:0]    b_re,
    input  logic signed [BW-1:0]    b_im,
    output logic                    out_vld,
    output logic signed [AW+BW:0]   p_re,
    output logic signed [AW+BW:0]   p_im
);
    localparam int PRW = AW + BW;
    localparam int PW  = PRW + 1;

    typedef struct packed {
        logic                  v1;
        logic signed [AW-1:0]  ar;
        logic signed [AW-1:0]  ai;
        logic signed [BW-1:0]  br;
        logic signed [BW-1:0]  bi;
        logic                  v2;
        logic signed [PRW-1:0] ac;
        logic signed [PRW-1:0] bd;
        logic signed [PRW-1:0] ad;
        logic signed [PRW-1:0] bc;
        logic                  v3;
        logic signed [PW-1:0]  cr;
        logic signed [PW-1:0]  ci;
        logic                  v4;
        logic signed [PW-1:0]  orr;
        logic signed [PW-1:0]  oi;
    } mul_st_t;

    mul_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.v1 = in_vld;
        if (in_vld) begin
            s_d.ar = a_re;
            s_d.ai = a_im;
            s_d.br = b_re;
            s_d.bi = b_im;
        end
        s_d.v2 = s_q.v1;
        if (s_q.v1) begin
            s_d.ac = PRW'(s_q.ar) * PRW'(s_q.br);
            s_d.bd = PRW'(s_q.ai) * PRW'(s_q.bi);
            s_d.ad = PRW'(s_q.ar) * PRW'(s_q.bi);
            s_d.bc = PRW'(s_q.ai) * PRW'(s_q.br);
        end
        s_d.v3 = s_q.v2;
        if (s_q.v2) begin
            s_d.cr = PW'(s_q.ac) - PW'(s_q.bd);
            s_d.ci = PW'(s_q.ad) + PW'(s_q.bc);
        end
        s_d.v4 = s_q.v3;
        if (s_q.v3) begin
            s_d.orr = s_q.cr;
            s_d.oi  = s_q.ci;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign out_vld = s_q.v4;
    assign p_re    = s_q.orr;
    assign p_im    = s_q.oi;

    // R8: product register holds when nothing valid reaches the last stage
    p_cmul_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !s_q.v3 |=> ($stable(p_re) && $stable(p_im)));
endmodule

// File: rtl/phase_coef_combiner.sv
`timescale 1ns/1ps
module phase_coef_combiner
    import phase_coef_pkg::*;
#(
    parameter int LOG_N = 3,
    parameter int IN_W  = 24,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [LOG_N-1:0]        row_idx,
    input  logic [LOG_N-1:0]        col_idx,
    input  logic signed [IN_W-1:0]  gx_re,
    input  logic signed [IN_W-1:0]  gx_im,
    input  logic signed [IN_W-1:0]  gy_re,
    input  logic signed [IN_W-1:0]  gy_im,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] coef_re,
    output logic signed [OUT_W-1:0] coef_im
);
    localparam int PROD_W    = MUL_W + TBL_W + 1;
    localparam int SUM_W     = PROD_W + 1;
    localparam int IN_SHIFT  = IN_W - MUL_W;
    localparam int OUT_SHIFT = FRAC + MUL_W - OUT_W;
    localparam int LATENCY   = 7;   // 1 input round + 4 multiply + 1 sum + 1 output round

    typedef struct packed {
        logic                    v;
        logic signed [MUL_W-1:0] xr;
        logic signed [MUL_W-1:0] xi;
        logic signed [MUL_W-1:0] yr;
        logic signed [MUL_W-1:0] yi;
        logic signed [TBL_W-1:0] fx;
        logic signed [TBL_W-1:0] fy;
        logic                    vs;
        logic signed [SUM_W-1:0] sre;
        logic signed [SUM_W-1:0] sim;
        logic                    vo;
        logic signed [OUT_W-1:0] ore;
        logic signed [OUT_W-1:0] oim;
    } comb_st_t;

    comb_st_t s_d, s_q;

    // input reduction to multiplier width
    logic signed [IN_W-1:0]  raw [4];
    logic signed [MUL_W-1:0] red [4];
    assign raw[0] = gx_re;
    assign raw[1] = gx_im;
    assign raw[2] = gy_re;
    assign raw[3] = gy_im;

    for (genvar gi = 0; gi < 4; gi++) begin : g_in_rnd
        rnd_sat #(.IW(IN_W), .OW(MUL_W), .SH(IN_SHIFT)) u_rnd (
            .din  (raw[gi]),
            .dout (red[gi])
        );
    end

    logic signed [TBL_W-1:0] fx_raw, fy_raw;
    phase_factor_rom #(.LOG_N(LOG_N)) u_rom (
        .row   (row_idx),
        .col   (col_idx),
        .fx_im (fx_raw),
        .fy_im (fy_raw)
    );

    // the weights are purely imaginary, so the real weight inputs are tied to zero
    localparam logic signed [TBL_W-1:0] ZERO_W = '0;

    logic                     xv, yv;
    logic signed [PROD_W-1:0] xp_re, xp_im, yp_re, yp_im;

    cplx_mul_pipe #(.AW(MUL_W), .BW(TBL_W)) u_mul_x (
        .clk (clk), .rst (rst), .in_vld (s_q.v),
        .a_re (s_q.xr), .a_im (s_q.xi), .b_re (ZERO_W), .b_im (s_q.fx),
        .out_vld (xv), .p_re (xp_re), .p_im (xp_im)
    );

    cplx_mul_pipe #(.AW(MUL_W), .BW(TBL_W)) u_mul_y (
        .clk (clk), .rst (rst), .in_vld (s_q.v),
        .a_re (s_q.yr), .a_im (s_q.yi), .b_re (ZERO_W), .b_im (s_q.fy),
        .out_vld (yv), .p_re (yp_re), .p_im (yp_im)
    );

    logic signed [OUT_W-1:0] ro_re, ro_im;
    rnd_sat #(.IW(SUM_W), .OW(OUT_W), .SH(OUT_SHIFT)) u_out_re (.din(s_q.sre), .dout(ro_re));
    rnd_sat #(.IW(SUM_W), .OW(OUT_W), .SH(OUT_SHIFT)) u_out_im (.din(s_q.sim), .dout(ro_im));

    always_comb begin
        s_d   = s_q;
        s_d.v = in_valid;
        if (in_valid) begin
            s_d.xr = red[0];
            s_d.xi = red[1];
            s_d.yr = red[2];
            s_d.yi = red[3];
            s_d.fx = fx_raw;
            s_d.fy = fy_raw;
        end
        s_d.vs = xv & yv;
        if (xv & yv) begin
            s_d.sre = SUM_W'(xp_re) + SUM_W'(yp_re);
            s_d.sim = SUM_W'(xp_im) + SUM_W'(yp_im);
        end
        s_d.vo = s_q.vs;
        if (s_q.vs) begin
            s_d.ore = ro_re;
            s_d.oim = ro_im;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign out_valid = s_q.vo;
    assign coef_re   = s_q.ore;
    assign coef_im   = s_q.oim;

    // cycles since reset, so the latency check never reaches back past reset
    logic [3:0] chk_age_q;
    always_ff @(posedge clk) begin
        if (rst)                         chk_age_q <= '0;
        else if (chk_age_q < 4'(LATENCY)) chk_age_q <= chk_age_q + 4'd1;
    end

    p_valid_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (chk_age_q == 4'(LATENCY)) |-> (out_valid == $past(in_valid, LATENCY)));

    p_dc_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && row_idx == '0 && col_idx == '0) |=> (s_q.fx == '0 && s_q.fy == '0));

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !s_q.vs |=> ($stable(coef_re) && $stable(coef_im)));
endmodule

// File: tb/phase_coef_combiner_test.sv
`timescale 1ns/1ps
module phase_coef_combiner_test;
    localparam int LOG_N = 3;
    localparam int N     = 1 << LOG_N;
    localparam int IN_W  = 24;
    localparam int OUT_W = 16;
    localparam int MAXQ  = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [LOG_N-1:0] row_idx = '0, col_idx = '0;
    logic signed [IN_W-1:0] gx_re = '0, gx_im = '0, gy_re = '0, gy_im = '0;
    logic out_valid;
    logic signed [OUT_W-1:0] coef_re, coef_im;

    phase_coef_combiner #(.LOG_N(LOG_N), .IN_W(IN_W), .OUT_W(OUT_W)) uut (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .row_idx (row_idx), .col_idx (col_idx),
        .gx_re (gx_re), .gx_im (gx_im), .gy_re (gy_re), .gy_im (gy_im),
        .out_valid (out_valid), .coef_re (coef_re), .coef_im (coef_im)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    longint exp_re [MAXQ];
    longint exp_im [MAXQ];
    string  exp_tag [MAXQ];
    int     sent_cyc [MAXQ];
    int ndrv = 0, nsent = 0, nrecv = 0, pcnt = 0;
    bit seen_out = 1'b0;
    logic signed [OUT_W-1:0] last_re = '0, last_im = '0;
    logic [31:0] seed = 32'h1234_5678;

    function automatic longint rnd(longint v, int sh, int w);
        longint t;
        longint hi;
        t  = (v + (64'sd1 <<< (sh - 1))) >>> sh;
        hi = (64'sd1 <<< (w - 1)) - 1;
        if (t > hi) return hi;
        if (t < -hi - 1) return -hi - 1;
        return t;
    endfunction

    function automatic longint weight(int r, int c);
        int p;
        int q;
        int d;
        p = (r >= N / 2) ? r - N : r;
        q = (c >= N / 2) ? c - N : c;
        d = p * p + q * q;
        if (d == 0) return 0;
        return longint'($floor(real'(p) * 16384.0 / real'(d) + 0.5));
    endfunction

    task automatic check(string tag, longint act, longint expv, int tol);
        longint diff;
        diff = act - expv;
        checks++;
        if (diff > tol || diff < -tol) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic send(int r, int c, longint xr, longint xi, longint yr, longint yi, string tag);
        longint ar, ai, br, bi, fx, fy;
        @(negedge clk);
        in_valid = 1'b1;
        row_idx  = LOG_N'(r);
        col_idx  = LOG_N'(c);
        gx_re = IN_W'(xr); gx_im = IN_W'(xi);
        gy_re = IN_W'(yr); gy_im = IN_W'(yi);
        ar = rnd(xr, 6, 18); ai = rnd(xi, 6, 18);
        br = rnd(yr, 6, 18); bi = rnd(yi, 6, 18);
        fx = weight(r, c);
        fy = weight(c, r);
        exp_re[ndrv]  = rnd(-(ai * fx) - (bi * fy), 16, 16);
        exp_im[ndrv]  = rnd(ar * fx + br * fy, 16, 16);
        exp_tag[ndrv] = tag;
        ndrv++;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic longint next_val(int bits);
        seed = seed * 32'd1664525 + 32'd1013904223;
        if (bits >= 24) return longint'($signed(seed[31:8]));
        return longint'($signed(seed[19:8]));
    endfunction

    // record the posedge index at which each sample is accepted
    always @(posedge clk) begin
        if (!rst && in_valid && nsent < MAXQ) begin
            sent_cyc[nsent] = pcnt;
            nsent = nsent + 1;
        end
        pcnt = pcnt + 1;
    end

    // output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            check("R9 reset out_valid", longint'(out_valid), 0, 0);
            check("R9 reset coef_re", longint'(coef_re), 0, 0);
            check("R9 reset coef_im", longint'(coef_im), 0, 0);
        end else if (out_valid) begin
            if (nrecv >= nsent) begin
                checks++;
                failures++;
                $display("FAIL R6 unexpected output actual=%0d expected=%0d", nrecv + 1, nsent);
            end else begin
                check("R6 latency", longint'(pcnt - sent_cyc[nrecv]), 7, 0);
                check({exp_tag[nrecv], " real"}, longint'(coef_re), exp_re[nrecv], 1);
                check({exp_tag[nrecv], " imag"}, longint'(coef_im), exp_im[nrecv], 1);
            end
            nrecv++;
            last_re  = coef_re;
            last_im  = coef_im;
            seen_out = 1'b1;
        end else if (seen_out) begin
            check("R8 hold real", longint'(coef_re), longint'(last_re), 0);
            check("R8 hold imag", longint'(coef_im), longint'(last_im), 0);
        end
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // full 8x8 frame, back to back, wide random values (R5, R6, R2 at DC)
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                send(r, c, next_val(24), next_val(24), next_val(24), next_val(24),
                     (r == 0 && c == 0) ? "R2 dc bin" : "R5 frame");
        idle(3);

        // gapped 8x8 frame with small values (R6, R8, R5)
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                send(c, r, next_val(12), next_val(12), next_val(12), next_val(12),
                     (r == 0 && c == 0) ? "R2 dc bin" : "R5 gapped");
                idle(2);
            end

        // R1: x path alone at (1,0) and (5,3)
        send(1, 0, 64'sd4194304, 0, 0, 0, "R1 weight p=1 q=0");
        send(5, 3, 64'sd4194304, 64'sd1048576, 0, 0, "R1 weight p=-3 q=3");
        // R3: y path alone at transposed positions
        send(1, 2, 0, 0, 64'sd4194304, 0, "R3 transpose (1,2)");
        send(2, 1, 0, 0, 64'sd4194304, 0, "R3 transpose (2,1)");
        send(6, 1, 0, 0, 64'sd2097152, -64'sd3145728, "R3 transpose (6,1)");
        // R2: large values at DC give zero
        send(0, 0, 64'sd8388607, -64'sd8388608, 64'sd8388607, 64'sd8388607, "R2 dc large");
        // R4: input saturation before the multiply
        send(1, 1, 64'sd8388607, 0, 0, 0, "R4 input saturation");
        send(1, 0, 0, -64'sd8388608, 0, 0, "R4 input negative rail");
        // R7: output saturation after rounding
        send(1, 1, 64'sd8388607, 0, 64'sd8388607, 0, "R7 output saturation");
        send(1, 1, -64'sd8388608, 0, -64'sd8388608, 0, "R7 output negative rail");
        idle(20);

        check("R6 output count", longint'(nrecv), longint'(ndrv), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule